// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It looks up a flat page table held in memory. The table has one 4-byte entry for every 4 KB virtual page, so it holds 2^20 entries and occupies 4 MB. Each translation costs exactly one memory read.

A requester hands over a virtual address while the walker is idle. The walker keeps that address and the current table base. It computes where the entry lives and issues one word read on a request/response memory port. Once the entry returns, the walker reports one of two outcomes:

- **Translation done:** the entry is marked present. The walker pulses a done signal and gives the physical address, built from the entry's frame number and the page offset.
- **Page fault:** the entry is not marked present. The walker pulses a fault signal instead, leaving the fault to software.

Any virtual page may map to any physical frame.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid`, `xlate_done` and `xlate_fault` are 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while idle. `req_valid` during a walk has no effect on the read address or on the result.
- R3: The entry address is `pt_base + (req_vaddr[31:12] << 2)`, computed modulo 2^32. Both `req_vaddr` and `pt_base` are sampled at acceptance, so later changes on them have no effect.
- R4: Each translation makes exactly one read. `mem_req_valid` rises in the cycle after acceptance. It then holds, with `mem_req_addr` unchanged, until a clock edge where `mem_req_ready` is 1, and falls in the next cycle.
- R5: A response is taken only after the read handshake. A `mem_rsp_valid` seen while the read is still waiting for `mem_req_ready`, or while idle, is ignored.
- R6: If bit 31 of the returned entry is 1, `xlate_done` is 1 for exactly one cycle. In that cycle `xlate_paddr` equals the entry's bits [19:0] followed by `req_vaddr[11:0]`. Entry bits [30:20] do not affect the result.
- R7: If bit 31 of the returned entry is 0, `xlate_fault` is 1 for exactly one cycle and `xlate_done` stays 0.
- R8: The done or fault pulse appears in the cycle after the response edge. `req_ready` returns to 1 in the cycle after that pulse.
- R9: The memory may stall the read handshake and the response for any number of cycles without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| pt_base | input | 32 | Byte address of the page table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Page table entry word |
| xlate_done | output | 1 | One-cycle pulse: translation succeeded |
| xlate_paddr | output | 32 | Physical address, valid with `xlate_done` |
| xlate_fault | output | 1 | One-cycle pulse: page not present |

## Verification
The bench drives several request patterns:

- Addresses at the extremes (all zeros and all ones) and a base that wraps past 2^32 check that the entry address is formed and truncated correctly.
- Present and absent entries, with noise in the unused entry bits, separate the done path from the fault path and show that only bit 31 and the frame field matter.
- Zero-latency memory and long stalls on both the handshake and the response check the hold-until-accepted rule and the exact pulse timing.
- Runs that keep `req_valid` high, change the address and base mid-walk, and send stray responses before the handshake show that these inputs are ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        WS_IDLE  = 3'd0,
        WS_ISSUE = 3'd1,
        WS_WAIT  = 3'd2,
        WS_DONE  = 3'd3,
        WS_FAULT = 3'd4
    } walk_state_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PTE_BYTES = 4
) (
    input  logic [VA_W-1:0] base_i,
    input  logic [VA_W-1:0] vaddr_i,
    output logic [VA_W-1:0] entry_addr_o
);
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int SHIFT = $clog2(PTE_BYTES);

    logic [VPN_W-1:0] vpn;
    logic [VA_W-1:0]  vpn_ext;
    logic [VA_W-1:0]  byte_off;

    always_comb begin
        vpn          = vaddr_i[VA_W-1:PAGE_BITS];
        vpn_ext      = {{PAGE_BITS{1'b0}}, vpn};
        byte_off     = vpn_ext << SHIFT;
        entry_addr_o = base_i + byte_off;
    end
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int PTE_W     = 32,
    parameter int VALID_POS = 31,
    parameter int PFN_W     = 20
) (
    input  logic [PTE_W-1:0] pte_i,
    output logic             present_o,
    output logic [PFN_W-1:0] pfn_o
);
    always_comb begin
        present_o = pte_i[VALID_POS];
        pfn_o     = pte_i[PFN_W-1:0];
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PFN_W     = 20,
    parameter int PA_W      = PFN_W + PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic [VA_W-1:0]  base_i,
    input  logic             mem_ready_i,
    input  logic             rsp_valid_i,
    input  logic             pte_present_i,
    input  logic [PFN_W-1:0] pte_pfn_i,
    output logic             req_ready_o,
    output logic             mem_valid_o,
    output logic [VA_W-1:0]  held_vaddr_o,
    output logic [VA_W-1:0]  held_base_o,
    output logic             done_o,
    output logic             fault_o,
    output logic [PA_W-1:0]  paddr_o
);
    typedef struct packed {
        walk_state_e      st;
        logic [VA_W-1:0]  vaddr;
        logic [VA_W-1:0]  base;
        logic [PA_W-1:0]  paddr;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            WS_IDLE: begin
                if (req_valid_i) begin
                    r_d.st    = WS_ISSUE;
                    r_d.vaddr = req_vaddr_i;
                    r_d.base  = base_i;
                end
            end
            WS_ISSUE: begin
                if (mem_ready_i) begin
                    r_d.st = WS_WAIT;
                end
            end
            WS_WAIT: begin
                if (rsp_valid_i) begin
                    if (pte_present_i) begin
                        r_d.st    = WS_DONE;
                        r_d.paddr = {pte_pfn_i, r_q.vaddr[PAGE_BITS-1:0]};
                    end else begin
                        r_d.st = WS_FAULT;
                    end
                end
            end
            WS_DONE:  r_d.st = WS_IDLE;
            WS_FAULT: r_d.st = WS_IDLE;
            default:  r_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= WS_IDLE;
            r_q.vaddr <= '0;
            r_q.base  <= '0;
            r_q.paddr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready_o  = (r_q.st == WS_IDLE);
        mem_valid_o  = (r_q.st == WS_ISSUE);
        done_o       = (r_q.st == WS_DONE);
        fault_o      = (r_q.st == WS_FAULT);
        held_vaddr_o = r_q.vaddr;
        held_base_o  = r_q.base;
        paddr_o      = r_q.paddr;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PTE_W     = 32,
    parameter int PFN_W     = 20,
    parameter int VALID_POS = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [VA_W-1:0]  pt_base,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [VA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             xlate_done,
    output logic [PFN_W+PAGE_BITS-1:0] xlate_paddr,
    output logic             xlate_fault
);
    localparam int PA_W      = PFN_W + PAGE_BITS;
    localparam int PTE_BYTES = PTE_W / 8;

    logic             pte_present;
    logic [PFN_W-1:0] pte_pfn;
    logic [VA_W-1:0]  held_vaddr;
    logic [VA_W-1:0]  held_base;

    ptw_pte_decode #(
        .PTE_W    (PTE_W),
        .VALID_POS(VALID_POS),
        .PFN_W    (PFN_W)
    ) u_decode (
        .pte_i    (mem_rsp_data),
        .present_o(pte_present),
        .pfn_o    (pte_pfn)
    );

    ptw_ctrl #(
        .VA_W     (VA_W),
        .PAGE_BITS(PAGE_BITS),
        .PFN_W    (PFN_W),
        .PA_W     (PA_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_vaddr_i  (req_vaddr),
        .base_i       (pt_base),
        .mem_ready_i  (mem_req_ready),
        .rsp_valid_i  (mem_rsp_valid),
        .pte_present_i(pte_present),
        .pte_pfn_i    (pte_pfn),
        .req_ready_o  (req_ready),
        .mem_valid_o  (mem_req_valid),
        .held_vaddr_o (held_vaddr),
        .held_base_o  (held_base),
        .done_o       (xlate_done),
        .fault_o      (xlate_fault),
        .paddr_o      (xlate_paddr)
    );

    ptw_addr_gen #(
        .VA_W     (VA_W),
        .PAGE_BITS(PAGE_BITS),
        .PTE_BYTES(PTE_BYTES)
    ) u_addr (
        .base_i      (held_base),
        .vaddr_i     (held_vaddr),
        .entry_addr_o(mem_req_addr)
    );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PTE_W     = 32,
    parameter int PFN_W     = 20,
    parameter int VALID_POS = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [VA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic [PTE_W-1:0] mem_rsp_data,
    input logic             xlate_done,
    input logic [PFN_W+PAGE_BITS-1:0] xlate_paddr,
    input logic             xlate_fault
);
    // R4: a pending read keeps its request and address
    p_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4: one read per walk, dropped after the handshake
    p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R2: never reading while open for new work
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !xlate_done && !xlate_fault));

    // R6: done follows a present entry and carries its frame
    p_done_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xlate_done |-> ($past(mem_rsp_valid && mem_rsp_data[VALID_POS])
                        && xlate_paddr[PFN_W+PAGE_BITS-1:PAGE_BITS] == $past(mem_rsp_data[PFN_W-1:0])));

    // R7: fault follows an absent entry, never together with done
    p_fault_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xlate_fault |-> ($past(mem_rsp_valid && !mem_rsp_data[VALID_POS]) && !xlate_done));

    // R8: pulses last one cycle and the walker is idle next
    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xlate_done || xlate_fault) |=> (!xlate_done && !xlate_fault && req_ready));
endmodule

bind pt_walker ptw_checker #(
    .VA_W     (VA_W),
    .PAGE_BITS(PAGE_BITS),
    .PTE_W    (PTE_W),
    .PFN_W    (PFN_W),
    .VALID_POS(VALID_POS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .xlate_done   (xlate_done),
    .xlate_paddr  (xlate_paddr),
    .xlate_fault  (xlate_fault)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] pt_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        xlate_done;
    logic [31:0] xlate_paddr;
    logic        xlate_fault;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // reference model state: 0 idle, 1 issue, 2 wait, 3 done, 4 fault
    int          ph = 0;
    logic [31:0] m_va = '0;
    logic [31:0] m_base = '0;
    logic [31:0] m_pa = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .pt_base(pt_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .xlate_done(xlate_done),
        .xlate_paddr(xlate_paddr), .xlate_fault(xlate_fault)
    );

    function automatic logic [31:0] entry_of(logic [31:0] base, logic [31:0] va);
        return base + (va / 32'd4096) * 32'd4;
    endfunction

    function automatic logic [31:0] make_pte(logic [31:0] addr, logic present);
        logic [19:0] frame;
        logic [10:0] junk;
        frame = 20'((addr * 32'h9E3779B1) >> 9);
        junk  = addr[12:2] ^ 11'h5A5;
        return {present, junk, frame};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    task automatic compare();
        chk("R1/R2 req_ready", 32'(req_ready), 32'(ph == 0));
        chk("R4 mem_req_valid", 32'(mem_req_valid), 32'(ph == 1));
        if (ph == 1) chk("R3 mem_req_addr", mem_req_addr, m_base + {m_va[31:12], 2'b00});
        chk("R6/R8 xlate_done", 32'(xlate_done), 32'(ph == 3));
        chk("R7/R8 xlate_fault", 32'(xlate_fault), 32'(ph == 4));
        if (ph == 3) chk("R6 xlate_paddr", xlate_paddr, m_pa);
    endtask

    task automatic tick();
        @(posedge clk);
        cycles++;
        case (ph)
            0: if (req_valid) begin ph = 1; m_va = req_vaddr; m_base = pt_base; end
            1: if (mem_req_ready) ph = 2;
            2: if (mem_rsp_valid) begin
                   if (mem_rsp_data[31]) begin
                       ph = 3;
                       m_pa = {mem_rsp_data[19:0], m_va[11:0]};
                   end else begin
                       ph = 4;
                   end
               end
            default: ph = 0;
        endcase
        @(negedge clk);
        compare();
    endtask

    // one walk; noise holds req_valid, changes inputs and sends stray responses (R2, R3, R5)
    task automatic walk(logic [31:0] va, logic [31:0] base, int rd, int sd,
                        logic present, logic noise);
        logic [31:0] ea;
        ea = entry_of(base, va);
        req_valid = 1'b1; req_vaddr = va; pt_base = base;
        tick();
        if (noise) begin
            req_vaddr = ~va; pt_base = base ^ 32'h0F0F_0000;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < rd; i++) begin
            if (noise) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data = 32'h8000_0000 | (32'h1357 << i);
            end
            tick();
        end
        mem_rsp_valid = 1'b0;
        mem_req_ready = 1'b1;
        tick();
        mem_req_ready = 1'b0;
        for (int i = 0; i < sd; i++) tick();
        mem_rsp_valid = 1'b1;
        mem_rsp_data = make_pte(ea, present);
        tick();
        mem_rsp_valid = 1'b0;
        mem_rsp_data = 32'hFFFF_FFFF;
        req_valid = 1'b0;
        tick();
        tick();
    endtask

    always @(posedge clk) begin
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare();                                              // R1
        walk(32'h1234_5ABC, 32'h0040_0000, 0, 0, 1'b1, 1'b0);   // R6 fast path
        walk(32'hFFFF_FFFF, 32'h8000_0000, 3, 5, 1'b1, 1'b0);   // R9 stalls, top page
        walk(32'h0000_0000, 32'h0000_0000, 0, 2, 1'b1, 1'b0);   // R3 page zero
        walk(32'hDEAD_B123, 32'h0100_0000, 1, 1, 1'b0, 1'b0);   // R7 fault
        walk(32'hCAFE_F00D, 32'h0020_0000, 4, 3, 1'b1, 1'b1);   // R2 R5 noise
        walk(32'h7654_3210, 32'hFFFF_F000, 2, 0, 1'b1, 1'b0);   // R3 wrap
        walk(32'h0ABC_DFFF, 32'h0030_0000, 3, 7, 1'b0, 1'b1);   // R7 fault with noise
        walk(32'h8000_1000, 32'h0000_1000, 0, 0, 1'b1, 1'b0);   // R8 back to idle
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule